// File: doc/BRIEF.md
# Free-Running Timestamp Counter with Coherent Split Read

This block keeps a free-running timestamp, 40 bits wide by default, that advances by one on every cycle in which an external rate strobe is high and counting has been switched on. It has no interrupt output. Software sees it through a small 32-bit register window with two words. The low word returns the lower 32 bits of the count. The high word returns an 8-bit saved copy of the upper bits, plus a run bit that starts and stops counting.

The full value cannot be read in one 32-bit access. To keep it from tearing, every read of the low word also saves the counter's upper bits into a holding byte in the same clock edge. Reading the low word and then the high word therefore gives the lower and upper parts of one sampled instant. This holds even if the count carries into the upper bits between the two accesses.

The split is set by parameters `LOW_W` (up to 32) and `HIGH_W` (up to 8). The defaults of 32 and 8 give the 40-bit counter. Read data is registered: it is valid in the cycle after the read strobe and holds until the next read.

Top module: `ts_stamp_timer`

## Requirements
- R1: After reset the count, the saved byte and the run bit are all zero, so reads of the low word (byte offset 0x60) and the high word (byte offset 0x64) both return 0.
- R2: While the run bit is 1, the count increases by exactly one on each clock edge where `tick` is high. With `tick` low, or with the run bit 0, the count holds its value.
- R3: Bit 8 of the high word is the run bit. A write to 0x64 loads it from `wdata[8]`, where 1 starts counting and 0 stops it. A read of 0x64 returns it in bit 8.
- R4: A read of 0x64 returns the saved byte in bits 7:0. The remaining bits of the high word read as zero.
- R5: A read of 0x60 returns the count's lower `LOW_W` bits in `rdata`, taken at the edge where `rd_en` is sampled. The value appears in the following cycle and the upper bits are zero.
- R6: The same low-word read saves the count's upper `HIGH_W` bits into the holding byte. A later read of 0x64 returns that saved value, not the live upper bits.
- R7: Once every count bit is 1, the next counted tick wraps the count to zero.
- R8: The low word is read-only, so a write to 0x60 leaves the count unchanged. Writes to 0x64 do not alter the saved byte.
- R9: A read of any offset other than 0x60 and 0x64 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Rate strobe; one count per high cycle while running |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |

## Verification
The count is driven by several tick patterns: none at all, a strobe in every cycle, a strobe every third cycle, and ticks while stopped. Together these separate counting per strobe from counting per clock, and show whether the run bit really gates the count. A low read is placed just before a carry into the upper byte, and the high word is read only after that carry. This separates a true snapshot from a live view of the upper bits. A run up to all ones and one tick beyond checks the wrap. Writes to the low word, and writes to the high word with the low byte set, show whether the count and the saved byte are protected from writes.

// File: rtl/ts_pkg.sv
package ts_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int SNAP_MAX = 8;
    localparam int RUN_BIT  = 8;
    localparam logic [ADDR_W-1:0] OFS_LOW  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_HIGH = 8'h64;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_HIGH = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic                run;
        logic [SNAP_MAX-1:0] snap;
    } high_word_t;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        if (a == OFS_LOW)       return SEL_LOW;
        else if (a == OFS_HIGH) return SEL_HIGH;
        else                    return SEL_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] pack_high(input high_word_t h);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SNAP_MAX-1:0] = h.snap;
        w[RUN_BIT]      = h.run;
        return w;
    endfunction
endpackage

// File: rtl/ts_counter.sv
module ts_counter #(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    output logic [CNT_W-1:0] count
);
    logic step;
    assign step = tick & run;

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (step) count <= count + 1'b1;
    end

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && run) |=> count == $past(count) + 1'b1);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(tick && run) |=> $stable(count));
    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && run && (&count)) |=> count == '0);
endmodule

// File: rtl/ts_snapshot.sv
module ts_snapshot #(
    parameter int SNAP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [SNAP_W-1:0] top,
    output logic [SNAP_W-1:0] snap
);
    always_ff @(posedge clk) begin
        if (rst)          snap <= '0;
        else if (capture) snap <= top;
    end

    assert_snap_take_R6: assert property (@(posedge clk) disable iff (rst)
        capture |=> snap == $past(top));
    assert_snap_keep_R6: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(snap));
endmodule

// File: rtl/ts_regif.sv
module ts_regif
    import ts_pkg::*;
#(
    parameter int LOW_W  = 32,
    parameter int HIGH_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_run,
    input  logic [LOW_W-1:0]  cnt_low,
    input  logic [HIGH_W-1:0] snap,
    output logic              run,
    output logic              capture,
    output logic [DATA_W-1:0] rdata
);
    reg_sel_e          sel;
    high_word_t        hw;
    logic [DATA_W-1:0] rd_mux;

    assign sel     = decode(addr);
    assign capture = rd_en && (sel == SEL_LOW);

    always_comb begin
        hw.run  = run;
        hw.snap = SNAP_MAX'(snap);
        unique case (sel)
            SEL_LOW:  rd_mux = DATA_W'(cnt_low);
            SEL_HIGH: rd_mux = pack_high(hw);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            rdata <= '0;
        end else begin
            if (wr_en && sel == SEL_HIGH) run <= wr_run;
            if (rd_en) rdata <= rd_mux;
        end
    end

    assert_run_load_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_HIGH) |=> run == $past(wr_run));
    assert_run_keep_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == OFS_HIGH) |=> $stable(run));
    assert_low_read_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFS_LOW) |=> rdata == DATA_W'($past(cnt_low)));
    assert_other_read_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr != OFS_LOW && addr != OFS_HIGH) |=> rdata == '0);
endmodule

// File: rtl/ts_stamp_timer.sv
module ts_stamp_timer
    import ts_pkg::*;
#(
    parameter int LOW_W  = 32,
    parameter int HIGH_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int CNT_W = LOW_W + HIGH_W;

    logic [CNT_W-1:0]  count;
    logic [HIGH_W-1:0] snap;
    logic              run;
    logic              capture;
    logic              unused_wdata;

    assign unused_wdata = ^{wdata[DATA_W-1:RUN_BIT+1], wdata[RUN_BIT-1:0]};

    initial begin
        chk_widths: assert (LOW_W <= DATA_W && HIGH_W <= SNAP_MAX && LOW_W > 0 && HIGH_W > 0);
    end

    ts_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .run   (run),
        .count (count)
    );

    ts_snapshot #(.SNAP_W(HIGH_W)) u_snapshot (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .top     (count[CNT_W-1:LOW_W]),
        .snap    (snap)
    );

    ts_regif #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_regif (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_run  (wdata[RUN_BIT]),
        .cnt_low (count[LOW_W-1:0]),
        .snap    (snap),
        .run     (run),
        .capture (capture),
        .rdata   (rdata)
    );

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (count == '0 && snap == '0 && !run && rdata == '0));
endmodule

// File: tb/ts_stamp_timer_bench.sv
`timescale 1ns/1ps
module ts_stamp_timer_bench;
    localparam int LW = 8;
    localparam int HW = 8;
    localparam int CW = LW + HW;
    localparam logic [7:0] A_LOW  = 8'h60;
    localparam logic [7:0] A_HIGH = 8'h64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_chk  = 0;
    int n_fail = 0;

    logic [CW-1:0] m_cnt;
    logic [HW-1:0] m_snap;
    logic          m_run;

    always #10 clk = ~clk;

    ts_stamp_timer #(.LOW_W(LW), .HIGH_W(HW)) u_ts_stamp_timer (
        .clk(clk), .rst(rst), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // reference state built from the requirements
    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0; m_snap <= '0; m_run <= 1'b0;
        end else begin
            if (tick && m_run) m_cnt <= m_cnt + 1'b1;
            if (wr_en && addr == A_HIGH) m_run <= wdata[8];
            if (rd_en && addr == A_LOW) m_snap <= m_cnt[CW-1:LW];
        end
    end

    function automatic logic [31:0] exp_low();
        return 32'(m_cnt[LW-1:0]);
    endfunction

    function automatic logic [31:0] exp_high();
        return {23'b0, m_run, m_snap};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic run_ticks(input int n, input int every);
        for (int i = 0; i < n; i++) begin
            tick = (i % every) == 0;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    task automatic read_low_chk(input string req);
        logic [31:0] e, v;
        e = exp_low();
        do_read(A_LOW, v);
        check(req, v, e);
    endtask

    task automatic read_high_chk(input string req);
        logic [31:0] e, v;
        e = exp_high();
        do_read(A_HIGH, v);
        check(req, v, e);
    endtask

    task automatic t_reset();
        read_low_chk("R1 low after reset");
        read_high_chk("R1 high after reset");
        check("R1 rdata zero", rdata, 32'h0);
    endtask

    task automatic t_stopped();
        run_ticks(20, 1);
        read_low_chk("R2 ticks ignored while stopped");
        check("R2 still zero", rdata, 32'h0);
    endtask

    task automatic t_start();
        do_write(A_HIGH, 32'h0000_0100);
        read_high_chk("R3 run bit reads back");
        check("R3 bit8 set", rdata & 32'h100, 32'h100);
    endtask

    task automatic t_patterns();
        run_ticks(30, 1);
        read_low_chk("R2 every-cycle ticks");
        check("R2 count 30", rdata, 32'd30);
        run_ticks(30, 3);
        read_low_chk("R2 every-third ticks");
        check("R2 count 40", rdata, 32'd40);
        run_ticks(15, 1000);
        read_low_chk("R2 single tick");
        repeat (10) @(negedge clk);
        read_low_chk("R2 hold without tick");
    endtask

    task automatic t_snapshot();
        run_ticks(16'h01F0 - int'(m_cnt), 1);
        read_low_chk("R5 low before carry");
        check("R5 low byte F0", rdata, 32'hF0);
        run_ticks(32, 1);
        read_high_chk("R6 snapshot not live");
        check("R6 snapshot 01", rdata, 32'h101);
        read_low_chk("R5 low after carry");
        read_high_chk("R6 new snapshot");
        check("R6 snapshot 02", rdata, 32'h102);
    endtask

    task automatic t_writes();
        logic [31:0] v;
        do_write(A_LOW, 32'hFFFF_FFFF);
        read_low_chk("R8 low write ignored");
        do_write(A_HIGH, 32'h0000_01AA);
        read_high_chk("R8 snap not written");
        check("R4 high layout", rdata, 32'h100 | 32'(m_snap));
        do_read(8'h68, v);
        check("R9 other offset", v, 32'h0);
        do_read(8'h00, v);
        check("R9 offset zero", v, 32'h0);
    endtask

    task automatic t_stop();
        logic [31:0] e;
        do_write(A_HIGH, 32'h0);
        e = exp_low();
        run_ticks(25, 1);
        read_low_chk("R3 stopped holds");
        check("R3 stopped value", rdata, e);
        read_high_chk("R3 run bit cleared");
        do_write(A_HIGH, 32'h100);
    endtask

    task automatic t_wrap();
        run_ticks(16'hFFFF - int'(m_cnt), 1);
        read_low_chk("R7 at all ones low");
        read_high_chk("R7 at all ones high");
        check("R7 high FF", rdata, 32'h1FF);
        run_ticks(1, 1);
        read_low_chk("R7 wrapped low");
        check("R7 zero", rdata, 32'h0);
        read_high_chk("R7 wrapped high");
        check("R7 high zero", rdata, 32'h100);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_stopped();
        t_start();
        t_patterns();
        t_snapshot();
        t_writes();
        t_stop();
        t_wrap();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule